// File: doc/BRIEF.md
# Banked Scratchpad with Conflict Replay

This block is a shared on-chip scratchpad that serves one group of lane requests at a time. The storage is split into word-interleaved banks. Each lane of a group has an active bit, a read/write bit, a word address and write data. A bank handles one row per cycle. Lanes that land in different banks, or that want the same word of a bank, are served in the same pass. Lanes that want different rows of one bank are replayed over further passes.

A group is accepted in any cycle where `req_valid_i` is high and `stall_o` is low. The block then raises `stall_o` and keeps it high for one cycle per replay pass. Each read lane gets its data back on `rd_data_o`, with a one-cycle strobe on `rd_valid_o`, in the cycle after the pass that served it. A new group may be presented in the cycle where the last read data appears.

Top module: `banked_scratchpad`

## Requirements
- R1: After reset `stall_o` is low and `rd_valid_o` is all zero.
- R2: The bank of a lane is word address bits [3:0] and its row is the bits above them. Sixteen lanes that read or write sixteen consecutive word addresses are all served in one pass, so `stall_o` is high for exactly one cycle.
- R3: A bank serves only one row per pass. The number of cycles `stall_o` stays high equals the largest count of distinct rows asked of any single bank in the group.
- R4: Any number of lanes that read the same word are served together in one pass, and each of them receives that word.
- R5: In each pass, a bank serves the row of its lowest-numbered pending lane, together with every other pending lane that wants that same row. Lanes with other rows wait for later passes.
- R6: When several lanes write the same word in one pass, the word keeps the data of the highest-numbered of those lanes.
- R7: A read lane served in pass p (pass 1 runs in the first cycle after acceptance) shows `rd_valid_o` high for exactly one cycle, in cycle p+1, with the word's data on its slice of `rd_data_o`. A write lane never raises `rd_valid_o`.
- R8: Lanes whose active bit is low access no bank and never raise `rd_valid_o`.
- R9: A request presented while `stall_o` is high is ignored and changes no stored word.
- R10: When a read and a write hit the same word in the same pass, the read returns the contents the word had before that write.
- R11: `stall_o` rises in the cycle after a group with at least one active lane is accepted, and it falls after the last pass. A group with no active lanes leaves `stall_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | A request group is presented |
| lane_act_i | input | LANES | Per-lane active bit |
| lane_we_i | input | LANES | Per-lane write (1) or read (0) |
| lane_addr_i | input | LANES*ADDR_W | Per-lane word address |
| lane_wdata_i | input | LANES*DATA_W | Per-lane write data |
| stall_o | output | 1 | Group in progress; new requests are ignored |
| rd_valid_o | output | LANES | Per-lane read data strobe |
| rd_data_o | output | LANES*DATA_W | Per-lane read data |

## Verification
The bench drives sixteen lanes into one bank on sixteen different rows. A design that merged the rows, or that picked lanes in the wrong order, would return data in the wrong cycles or with the wrong stall length. A broadcast group and a mixed group with two lanes sharing a row test the rule that equal words are not a conflict; a design that counted them as a conflict would add passes. Same-word write collisions, and a read and a write to one word in the same pass, expose a wrong winner lane or the wrong read-versus-write order. Writes presented during a stall and an empty group would corrupt memory or raise a spurious stall in a design that failed to ignore them.

// File: rtl/spad_pkg.sv
package spad_pkg;
  localparam int unsigned DEF_LANES  = 16;
  localparam int unsigned DEF_BANKS  = 16;
  localparam int unsigned DEF_ADDR_W = 10;
  localparam int unsigned DEF_DATA_W = 32;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_REPLAY = 1'b1
  } spad_state_e;
endpackage

// File: rtl/spad_bank_mem.sv
module spad_bank_mem #(
  parameter int unsigned ROW_W  = 6,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned ROWS  = 1 << ROW_W
) (
  input  logic              clk_i,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [ROWS];
  logic [DATA_W-1:0] rdata_q;

  // read returns the word as it was before a same-cycle write
  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[row_i] <= wdata_i;
    if (rd_en_i) rdata_q <= mem_q[row_i];
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/spad_bank_arb.sv
module spad_bank_arb #(
  parameter int unsigned LANES   = 16,
  parameter int unsigned BANK_W  = 4,
  parameter int unsigned ROW_W   = 6,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned BANK_ID = 0
) (
  input  logic [LANES-1:0]             pend_i,
  input  logic [LANES-1:0]             we_i,
  input  logic [LANES-1:0][BANK_W-1:0] bank_i,
  input  logic [LANES-1:0][ROW_W-1:0]  row_i,
  input  logic [LANES-1:0][DATA_W-1:0] wdata_i,
  output logic [LANES-1:0]             grant_o,
  output logic [ROW_W-1:0]             row_o,
  output logic                         rd_en_o,
  output logic                         wr_en_o,
  output logic [DATA_W-1:0]            wdata_o
);
  logic [LANES-1:0] hit;
  logic [ROW_W-1:0] lead_row;

  always_comb begin
    for (int l = 0; l < LANES; l++)
      hit[l] = pend_i[l] && (bank_i[l] == BANK_W'(BANK_ID));
  end

  // leader is the lowest-numbered pending lane in this bank
  always_comb begin
    lead_row = '0;
    for (int l = LANES - 1; l >= 0; l--)
      if (hit[l]) lead_row = row_i[l];
  end

  always_comb begin
    grant_o = '0;
    rd_en_o = 1'b0;
    wr_en_o = 1'b0;
    wdata_o = '0;
    for (int l = 0; l < LANES; l++) begin
      if (hit[l] && row_i[l] == lead_row) begin
        grant_o[l] = 1'b1;
        if (we_i[l]) begin
          wr_en_o = 1'b1;
          wdata_o = wdata_i[l]; // later lane overrides: highest wins
        end else begin
          rd_en_o = 1'b1;
        end
      end
    end
  end

  assign row_o = lead_row;
endmodule

// File: rtl/spad_lane_return.sv
module spad_lane_return #(
  parameter int unsigned LANES  = 16,
  parameter int unsigned BANKS  = 16,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned BANK_W = $clog2(BANKS)
) (
  input  logic [LANES-1:0]             valid_i,
  input  logic [LANES-1:0][BANK_W-1:0] bank_i,
  input  logic [BANKS-1:0][DATA_W-1:0] bank_rdata_i,
  output logic [LANES-1:0][DATA_W-1:0] rd_data_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign rd_data_o[l] = valid_i[l] ? bank_rdata_i[bank_i[l]] : '0;
  end
endmodule

// File: rtl/banked_scratchpad.sv
module banked_scratchpad
  import spad_pkg::*;
#(
  parameter int unsigned LANES  = DEF_LANES,
  parameter int unsigned BANKS  = DEF_BANKS,
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  parameter int unsigned DATA_W = DEF_DATA_W
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         req_valid_i,
  input  logic [LANES-1:0]             lane_act_i,
  input  logic [LANES-1:0]             lane_we_i,
  input  logic [LANES-1:0][ADDR_W-1:0] lane_addr_i,
  input  logic [LANES-1:0][DATA_W-1:0] lane_wdata_i,
  output logic                         stall_o,
  output logic [LANES-1:0]             rd_valid_o,
  output logic [LANES-1:0][DATA_W-1:0] rd_data_o
);
  localparam int unsigned BANK_W = $clog2(BANKS);
  localparam int unsigned ROW_W  = ADDR_W - BANK_W;

  spad_state_e                  state_q;
  logic [LANES-1:0]             pend_q;
  logic [LANES-1:0]             we_q;
  logic [LANES-1:0][ADDR_W-1:0] addr_q;
  logic [LANES-1:0][DATA_W-1:0] wdata_q;
  logic [LANES-1:0]             rd_valid_q;

  logic [LANES-1:0][BANK_W-1:0] lane_bank;
  logic [LANES-1:0][ROW_W-1:0]  lane_row;
  logic [LANES-1:0]             arb_pend;
  logic [BANKS-1:0][LANES-1:0]  bank_grant;
  logic [BANKS-1:0][DATA_W-1:0] bank_rdata;
  logic [LANES-1:0]             grant_all;
  logic [LANES-1:0]             pend_next;
  logic                         accept;

  assign accept  = req_valid_i && (state_q == ST_IDLE) && (lane_act_i != '0);
  assign arb_pend = (state_q == ST_REPLAY) ? pend_q : '0;

  for (genvar l = 0; l < LANES; l++) begin : g_split
    assign lane_bank[l] = addr_q[l][BANK_W-1:0];
    assign lane_row[l]  = addr_q[l][ADDR_W-1:BANK_W];
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [ROW_W-1:0]  row;
    logic              rd_en;
    logic              wr_en;
    logic [DATA_W-1:0] wdata;

    spad_bank_arb #(
      .LANES  (LANES),
      .BANK_W (BANK_W),
      .ROW_W  (ROW_W),
      .DATA_W (DATA_W),
      .BANK_ID(b)
    ) u_arb (
      .pend_i (arb_pend),
      .we_i   (we_q),
      .bank_i (lane_bank),
      .row_i  (lane_row),
      .wdata_i(wdata_q),
      .grant_o(bank_grant[b]),
      .row_o  (row),
      .rd_en_o(rd_en),
      .wr_en_o(wr_en),
      .wdata_o(wdata)
    );

    spad_bank_mem #(
      .ROW_W (ROW_W),
      .DATA_W(DATA_W)
    ) u_mem (
      .clk_i  (clk_i),
      .rd_en_i(rd_en),
      .wr_en_i(wr_en),
      .row_i  (row),
      .wdata_i(wdata),
      .rdata_o(bank_rdata[b])
    );
  end

  always_comb begin
    grant_all = '0;
    for (int b = 0; b < BANKS; b++) grant_all |= bank_grant[b];
  end

  assign pend_next = pend_q & ~grant_all;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      pend_q     <= '0;
      we_q       <= '0;
      addr_q     <= '0;
      wdata_q    <= '0;
      rd_valid_q <= '0;
    end else begin
      rd_valid_q <= (state_q == ST_REPLAY) ? (grant_all & ~we_q) : '0;
      if (accept) begin
        state_q <= ST_REPLAY;
        pend_q  <= lane_act_i;
        we_q    <= lane_we_i;
        addr_q  <= lane_addr_i;
        wdata_q <= lane_wdata_i;
      end else if (state_q == ST_REPLAY) begin
        pend_q <= pend_next;
        if (pend_next == '0) state_q <= ST_IDLE;
      end
    end
  end

  spad_lane_return #(
    .LANES (LANES),
    .BANKS (BANKS),
    .DATA_W(DATA_W)
  ) u_ret (
    .valid_i     (rd_valid_q),
    .bank_i      (lane_bank),
    .bank_rdata_i(bank_rdata),
    .rd_data_o   (rd_data_o)
  );

  assign stall_o    = (state_q == ST_REPLAY);
  assign rd_valid_o = rd_valid_q;
endmodule

// File: rtl/spad_checker.sv
module spad_checker #(
  parameter int unsigned LANES = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic [LANES-1:0] lane_act_i,
  input logic             stall_o,
  input logic [LANES-1:0] rd_valid_o,
  input logic [LANES-1:0] pend_q,
  input logic [LANES-1:0] grant_all,
  input logic [LANES-1:0] we_q
);
  assert_accept_stall_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !stall_o && lane_act_i != '0) |=> stall_o);

  assert_idle_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_o && !(req_valid_i && lane_act_i != '0)) |=> !stall_o);

  assert_pass_progress_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> (grant_all != '0));

  assert_grant_pending_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_all & ~pend_q) == '0);

  assert_rd_after_pass_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o != '0) |-> $past(stall_o));

  assert_no_write_return_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> ((rd_valid_o & $past(we_q)) == '0));
endmodule

bind banked_scratchpad spad_checker #(.LANES(LANES)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .lane_act_i (lane_act_i),
  .stall_o    (stall_o),
  .rd_valid_o (rd_valid_o),
  .pend_q     (pend_q),
  .grant_all  (grant_all),
  .we_q       (we_q)
);

// File: tb/sim_banked_scratchpad.sv
module sim_banked_scratchpad;
  localparam int CLK_P  = 10;
  localparam int LANES  = 16;
  localparam int ADDR_W = 10;
  localparam int DATA_W = 32;
  localparam int WORDS  = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [LANES-1:0] act = '0, we = '0;
  logic [LANES-1:0][ADDR_W-1:0] addr = '0;
  logic [LANES-1:0][DATA_W-1:0] wd = '0;
  logic stall;
  logic [LANES-1:0] rd_valid;
  logic [LANES-1:0][DATA_W-1:0] rd_data;

  int checks = 0, fails = 0;
  logic [DATA_W-1:0] refm [WORDS];

  always #(CLK_P/2) clk = ~clk;

  banked_scratchpad u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid),
    .lane_act_i(act), .lane_we_i(we), .lane_addr_i(addr), .lane_wdata_i(wd),
    .stall_o(stall), .rd_valid_o(rd_valid), .rd_data_o(rd_data)
  );

  task automatic check(input bit ok, input string req, input longint act_v, input longint exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act_v, exp_v);
    end
  endtask

  // Apply one group, observe every cycle until stall drops, compare with the model.
  task automatic run_group(input logic [LANES-1:0] g_act, input logic [LANES-1:0] g_we,
                           input logic [LANES-1:0][ADDR_W-1:0] g_addr,
                           input logic [LANES-1:0][DATA_W-1:0] g_wd,
                           input bit inject, input int exp_stall, input string req);
    int epass [LANES];
    logic [DATA_W-1:0] edat [LANES];
    int gcnt [LANES];
    int gcyc [LANES];
    logic [DATA_W-1:0] gdat [LANES];
    logic [LANES-1:0] pend;
    int p = 0, scnt = 0, c = 1;
    pend = g_act;
    while (pend != '0) begin
      logic [LANES-1:0] served = '0;
      p++;
      for (int b = 0; b < 16; b++) begin
        int lead = -1;
        for (int l = 0; l < LANES; l++)
          if (lead < 0 && pend[l] && g_addr[l][3:0] == 4'(b)) lead = l;
        if (lead >= 0)
          for (int l = 0; l < LANES; l++)
            if (pend[l] && g_addr[l] == g_addr[lead]) begin
              served[l] = 1'b1;
              epass[l] = p;
              edat[l] = refm[g_addr[l]];
            end
      end
      for (int l = 0; l < LANES; l++)
        if (served[l] && g_we[l]) refm[g_addr[l]] = g_wd[l];
      pend &= ~served;
    end
    for (int l = 0; l < LANES; l++) begin gcnt[l] = 0; gcyc[l] = 0; gdat[l] = '0; end
    @(negedge clk);
    req_valid = 1'b1; act = g_act; we = g_we; addr = g_addr; wd = g_wd;
    @(negedge clk);
    forever begin
      req_valid = 1'b0;
      for (int l = 0; l < LANES; l++)
        if (rd_valid[l]) begin gcnt[l]++; gcyc[l] = c; gdat[l] = rd_data[l]; end
      if (!stall || c > 40) break;
      scnt++;
      if (inject) begin
        req_valid = 1'b1; act = '1; we = '1;
        for (int l = 0; l < LANES; l++) begin addr[l] = 10'd7; wd[l] = 32'hDEAD_0000 + l; end
      end
      @(negedge clk);
      c++;
    end
    check(scnt == exp_stall, {req, " stall cycles"}, scnt, exp_stall);
    check(scnt == p, {req, " stall vs passes"}, scnt, p);
    for (int l = 0; l < LANES; l++) begin
      if (g_act[l] && !g_we[l]) begin
        check(gcnt[l] == 1, {req, " R7 one strobe"}, gcnt[l], 1);
        check(gcyc[l] == epass[l] + 1, {req, " R7 return cycle"}, gcyc[l], epass[l] + 1);
        check(gdat[l] == edat[l], {req, " read data"}, gdat[l], edat[l]);
      end else begin
        check(gcnt[l] == 0, {req, " R8 no strobe"}, gcnt[l], 0);
      end
    end
  endtask

  task automatic t_reset;
    check(stall == 1'b0, "R1 stall", stall, 0);
    check(rd_valid == '0, "R1 rd_valid", rd_valid, 0);
  endtask

  task automatic t_fill;
    logic [LANES-1:0][ADDR_W-1:0] a;
    logic [LANES-1:0][DATA_W-1:0] d;
    for (int g = 0; g < 16; g++) begin
      for (int l = 0; l < LANES; l++) begin
        a[l] = ADDR_W'(g * 16 + l);
        d[l] = {16'hC0DE, 6'd0, a[l]};
      end
      run_group('1, '1, a, d, 1'b0, 1, "R2 fill");
    end
  endtask

  task automatic t_seq_read;
    logic [LANES-1:0][ADDR_W-1:0] a;
    for (int l = 0; l < LANES; l++) a[l] = ADDR_W'(37 + l);
    run_group('1, '0, a, '0, 1'b0, 1, "R2 consecutive");
  endtask

  task automatic t_one_bank;
    logic [LANES-1:0][ADDR_W-1:0] a;
    for (int l = 0; l < LANES; l++) a[l] = ADDR_W'(l * 16 + 3);
    run_group('1, '0, a, '0, 1'b0, 16, "R3 R5 one bank");
  endtask

  task automatic t_broadcast;
    logic [LANES-1:0][ADDR_W-1:0] a;
    for (int l = 0; l < LANES; l++) a[l] = 10'd37;
    run_group('1, '0, a, '0, 1'b0, 1, "R4 broadcast");
  endtask

  task automatic t_order;
    logic [LANES-1:0][ADDR_W-1:0] a = '0;
    a[0] = 10'h21; a[1] = 10'h11; a[2] = 10'h21; a[5] = 10'h44; a[6] = 10'h24;
    run_group(16'h0067, '0, a, '0, 1'b0, 2, "R5 R8 leader order");
  endtask

  task automatic t_collide;
    logic [LANES-1:0][ADDR_W-1:0] a = '0;
    logic [LANES-1:0][DATA_W-1:0] d = '0;
    a[3] = 10'd50; a[9] = 10'd50; a[12] = 10'd50;
    d[3] = 32'h1111_0003; d[9] = 32'h1111_0009; d[12] = 32'h1111_000C;
    run_group(16'h1208, 16'h1208, a, d, 1'b0, 1, "R6 write clash");
    a = '0; a[0] = 10'd50;
    run_group(16'h0001, '0, a, '0, 1'b0, 1, "R6 readback");
    check(refm[50] == 32'h1111_000C, "R6 model winner", refm[50], 32'h1111_000C);
  endtask

  task automatic t_rw_same;
    logic [LANES-1:0][ADDR_W-1:0] a = '0;
    logic [LANES-1:0][DATA_W-1:0] d = '0;
    a[0] = 10'd60; a[1] = 10'd60; d[1] = 32'h5A5A_0060;
    run_group(16'h0003, 16'h0002, a, d, 1'b0, 1, "R10 read before write");
    a = '0; a[4] = 10'd60;
    run_group(16'h0010, '0, a, '0, 1'b0, 1, "R10 new value");
  endtask

  task automatic t_ignore;
    logic [LANES-1:0][ADDR_W-1:0] a;
    for (int l = 0; l < LANES; l++) a[l] = ADDR_W'(l * 16 + 9);
    run_group('1, '0, a, '0, 1'b1, 16, "R9 stalled writes");
    a = '0; a[2] = 10'd7;
    run_group(16'h0004, '0, a, '0, 1'b0, 1, "R9 word unchanged");
  endtask

  task automatic t_empty;
    logic [LANES-1:0][ADDR_W-1:0] a;
    for (int l = 0; l < LANES; l++) a[l] = 10'd7;
    run_group('0, '1, a, '1, 1'b0, 0, "R11 empty group");
    a = '0; a[0] = 10'd7;
    run_group(16'h0001, '0, a, '0, 1'b0, 1, "R11 R8 word kept");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill();
    t_seq_read();
    t_one_bank();
    t_broadcast();
    t_order();
    t_collide();
    t_rw_same();
    t_ignore();
    t_empty();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule